// File: doc/BRIEF.md
# Four-Lane Pixel Merger

This block rebuilds a single, ordered pixel stream from a sensor link that splits each line across four lanes in round-robin fashion: lane k holds pixels k, k+4, k+8 and so on of the current line. Upstream logic delivers the four lanes already word-aligned and in one clock domain. A shared valid strobe marks each group of four 12-bit lane words, called a beat. The block also receives the separate horizontal and vertical sync pulses. It stores each beat in a small holding register and plays the four words out one per cycle in lane order.

On the output side, each pixel is tagged with framing flags. The first pixel after a horizontal pulse is marked as start of line. If a vertical pulse came before that line start, the same pixel is also marked as start of frame. The pixel whose position in the line equals the programmed line length minus one is marked as end of line. The line length is a run-time input and must be a multiple of the lane count. Beats that arrive faster than they can drain are dropped, and a sticky overflow flag records the loss.

Top module: `pix_lane_merge`

## Requirements
- R1: A synchronous reset, while held high, clears the holding register, the pending framing state, the line position counter and the overflow flag. In the cycle after reset, out_valid, out_sol, out_sof, out_eol and overflow are all low.
- R2: Lane k of in_lanes occupies bits [12k+11:12k]. An accepted beat is emitted over four consecutive cycles, starting in the cycle after the accepting clock edge. The order is lane 0, lane 1, lane 2, lane 3.
- R3: out_valid is high exactly while buffered pixels remain. A beat is accepted when the buffer is empty or is showing its last pixel. Beats spaced exactly four cycles apart therefore give an unbroken output run.
- R4: A beat whose valid arrives while more than one buffered pixel is still to be shown is dropped. The pixels already in the buffer come out unchanged, and overflow goes high on the next cycle.
- R5: overflow stays high once set and is cleared only by reset.
- R6: Only the first pixel emitted after a horizontal pulse carries out_sol.
- R7: out_sof is high only on an out_sol pixel, and only if a vertical pulse was seen since the last out_sof pixel. The vertical pulse by itself flags no pixel.
- R8: A horizontal pulse resets the line position to 0. Each emitted pixel advances it by one. The pixel at position line_len-1 carries out_eol, and the position then wraps to 0.
- R9: After an end of line, pixels that arrive with no new horizontal pulse carry no out_sol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat strobe for in_lanes |
| in_lanes | input | 48 | Four 12-bit lane words, lane 0 in the low bits |
| hsync | input | 1 | Horizontal pulse, one cycle |
| vsync | input | 1 | Vertical pulse, one cycle |
| line_len | input | 16 | Pixels per line, a multiple of four |
| out_valid | output | 1 | A pixel is present on out_pixel |
| out_pixel | output | 12 | Current pixel |
| out_sol | output | 1 | Start of line flag |
| out_eol | output | 1 | End of line flag |
| out_sof | output | 1 | Start of frame flag |
| overflow | output | 1 | Sticky flag for a dropped beat |

## Verification
A wrong drain index or remaining-pixel count shows up at once as a pixel from the wrong lane, or as a gap or extra cycle in out_valid, within the four cycles of the affected beat. A wrong pending flag or line counter does not show until the next line boundary: a start or end flag appears on the wrong pixel. A bad accept rule surfaces as overflow on properly spaced traffic, or as a missing overflow on early beats. The reference model is compared on every clock, so the first wrong cycle is reported.

// File: rtl/pix_merge_pkg.sv
package pix_merge_pkg;

    localparam int unsigned PIX_W_DEF = 12;
    localparam int unsigned LANES_DEF = 4;
    localparam int unsigned LEN_W_DEF = 16;

    typedef logic [PIX_W_DEF-1:0] pix_word_t;

    typedef struct packed {
        logic      valid;
        pix_word_t data;
        logic      sol;
        logic      eol;
        logic      sof;
    } pix_out_t;

    // true when a counter value sits at the last position of a line
    function automatic logic at_line_end(input logic [LEN_W_DEF-1:0] pos,
                                         input logic [LEN_W_DEF-1:0] len);
        return (len != '0) && (pos == len - LEN_W_DEF'(1));
    endfunction

endpackage

// File: rtl/pmg_hold_buf.sv
module pmg_hold_buf #(
    parameter int unsigned PIX_W = 12,
    parameter int unsigned LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [LANES*PIX_W-1:0] in_lanes,
    output logic                   out_valid,
    output logic [PIX_W-1:0]       out_data,
    output logic                   overflow
);
    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned REM_W = $clog2(LANES + 1);
    localparam logic [REM_W-1:0] REM_FULL = REM_W'(LANES);
    localparam logic [REM_W-1:0] REM_ONE  = REM_W'(1);

    logic [PIX_W-1:0] lane_w [LANES];
    logic [PIX_W-1:0] slot   [LANES];
    logic [IDX_W-1:0] rd_idx;
    logic [REM_W-1:0] remain;
    logic             accept;
    logic             busy;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_unpack
            assign lane_w[g] = in_lanes[g*PIX_W +: PIX_W];

            always_ff @(posedge clk) begin
                if (rst)         slot[g] <= '0;
                else if (accept) slot[g] <= lane_w[g];
            end
        end
    endgenerate

    // more than one pixel still to show: a new beat cannot land
    assign busy   = (remain > REM_ONE);
    assign accept = in_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain   <= '0;
            rd_idx   <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) begin
                remain <= REM_FULL;
                rd_idx <= '0;
            end else if (remain != '0) begin
                remain <= remain - REM_ONE;
                rd_idx <= rd_idx + IDX_W'(1);
            end
            if (in_valid && busy) overflow <= 1'b1;
        end
    end

    assign out_valid = (remain != '0);
    assign out_data  = slot[rd_idx];

    AST_OVF_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && busy) |=> overflow);                          // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);                                    // R5
    AST_ACCEPT_LANE0: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid && rd_idx == '0));                   // R2
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!out_valid && !overflow));                        // R1

endmodule

// File: rtl/pmg_framer.sv
module pmg_framer #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             emit,
    input  logic             hsync,
    input  logic             vsync,
    input  logic [LEN_W-1:0] line_len,
    output logic             sol,
    output logic             sof,
    output logic             eol
);
    import pix_merge_pkg::*;

    logic [LEN_W-1:0] pos;
    logic             sol_pend;
    logic             sof_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= '0;
            sol_pend <= 1'b0;
            sof_pend <= 1'b0;
        end else begin
            if (hsync)     pos <= '0;
            else if (emit) pos <= eol ? '0 : pos + LEN_W'(1);

            if (hsync)     sol_pend <= 1'b1;
            else if (emit) sol_pend <= 1'b0;

            if (vsync)                 sof_pend <= 1'b1;
            else if (emit && sol_pend) sof_pend <= 1'b0;
        end
    end

    assign sol = emit && sol_pend;
    assign sof = sol && sof_pend;
    assign eol = emit && at_line_end(pos, line_len);

    AST_SOL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (sol && !hsync) |=> !sol);                                 // R6
    AST_SOF_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (sof && !vsync) |=> !sof_pend);                            // R7

endmodule

// File: rtl/pix_lane_merge.sv
module pix_lane_merge
    import pix_merge_pkg::*;
#(
    parameter int unsigned PIX_W = PIX_W_DEF,
    parameter int unsigned LANES = LANES_DEF,
    parameter int unsigned LEN_W = LEN_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [LANES*PIX_W-1:0] in_lanes,
    input  logic                   hsync,
    input  logic                   vsync,
    input  logic [LEN_W-1:0]       line_len,
    output logic                   out_valid,
    output logic [PIX_W-1:0]       out_pixel,
    output logic                   out_sol,
    output logic                   out_eol,
    output logic                   out_sof,
    output logic                   overflow
);
    logic             buf_valid;
    logic [PIX_W-1:0] buf_data;
    logic             f_sol;
    logic             f_sof;
    logic             f_eol;

    pmg_hold_buf #(.PIX_W(PIX_W), .LANES(LANES)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_lanes (in_lanes),
        .out_valid(buf_valid),
        .out_data (buf_data),
        .overflow (overflow)
    );

    pmg_framer #(.LEN_W(LEN_W)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .emit    (buf_valid),
        .hsync   (hsync),
        .vsync   (vsync),
        .line_len(line_len),
        .sol     (f_sol),
        .sof     (f_sof),
        .eol     (f_eol)
    );

    assign out_valid = buf_valid;
    assign out_pixel = buf_data;
    assign out_sol   = f_sol;
    assign out_sof   = f_sof;
    assign out_eol   = f_eol;

    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
        (out_sol || out_eol) |-> out_valid);                       // R3

endmodule

// File: tb/pix_lane_merge_bench.sv
`timescale 1ns/1ps
module pix_lane_merge_bench;
    localparam int PW = 12;
    localparam int NL = 4;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [NL*PW-1:0] in_lanes;
    logic          hsync, vsync;
    logic [LW-1:0] line_len;
    logic          out_valid, out_sol, out_eol, out_sof, overflow;
    logic [PW-1:0] out_pixel;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pix_lane_merge u_pix_lane_merge (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_lanes(in_lanes),
        .hsync(hsync), .vsync(vsync), .line_len(line_len),
        .out_valid(out_valid), .out_pixel(out_pixel), .out_sol(out_sol),
        .out_eol(out_eol), .out_sof(out_sof), .overflow(overflow)
    );

    // behavioural reference
    int q[$];
    int pos;
    bit solp, sofp, ovf;

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); pos = 0; solp = 0; sofp = 0; ovf = 0;
        end else begin
            if (q.size() > 0) begin
                void'(q.pop_front());
                if (solp) begin solp = 0; sofp = 0; end
                pos = (pos == int'(line_len) - 1) ? 0 : pos + 1;
            end
            if (hsync) begin solp = 1; pos = 0; end
            if (vsync) sofp = 1;
            if (in_valid) begin
                if (q.size() == 0)
                    for (int k = 0; k < NL; k++) q.push_back(int'(in_lanes[k*PW +: PW]));
                else
                    ovf = 1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit ev;
        ev = (q.size() > 0);
        check("R3 out_valid", int'(out_valid), int'(ev));
        if (ev) check("R2 out_pixel", int'(out_pixel), q[0]);
        check("R6 out_sol", int'(out_sol), int'(ev && solp));
        check("R7 out_sof", int'(out_sof), int'(ev && solp && sofp));
        check("R8 out_eol", int'(out_eol), int'(ev && pos == int'(line_len) - 1));
        check("R4 overflow", int'(overflow), int'(ovf));
    endtask

    task automatic cyc(input bit v, input logic [NL*PW-1:0] d, input bit hs, input bit vs);
        in_valid = v; in_lanes = d; hsync = hs; vsync = vs;
        @(posedge clk);
        @(negedge clk);
        if (!rst) compare_all();
    endtask

    function automatic logic [NL*PW-1:0] mk(input int base);
        logic [NL*PW-1:0] r;
        for (int k = 0; k < NL; k++) r[k*PW +: PW] = PW'(base + k * 17);
        return r;
    endfunction

    task automatic beat(input int base);
        cyc(1, mk(base), 0, 0);
        for (int i = 0; i < NL - 1; i++) cyc(0, '0, 0, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1; in_valid = 0; in_lanes = '0; hsync = 0; vsync = 0; line_len = 16'd8;
        @(negedge clk); @(negedge clk);
        cyc(0, '0, 0, 0);
        rst = 0;
        // R1: idle after reset
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 overflow", int'(overflow), 0);
        check("R1 flags", int'({out_sol, out_sof, out_eol}), 0);

        // frame start then a line of two back-to-back beats
        cyc(0, '0, 0, 1);
        cyc(0, '0, 1, 0);
        cyc(1, mk(12'h100), 0, 0);
        // R2: lane 0 first, in the cycle after accept
        check("R2 first lane", int'(out_pixel), 12'h100);
        cyc(0, '0, 0, 0); cyc(0, '0, 0, 0); cyc(0, '0, 0, 0);
        beat(12'h200);
        // R3: spaced beats gave a continuous run, buffer drained now
        check("R3 no overflow on spaced beats", int'(overflow), 0);
        idle(1);

        // second line, no vertical pulse
        cyc(0, '0, 1, 0);
        beat(12'h300); beat(12'h400);
        idle(2);
        // R9: beat after end of line without hsync
        cyc(1, mk(12'h500), 0, 0);
        check("R9 no sol without hsync", int'(out_sol), 0);
        idle(4);

        // R4: early beat dropped
        cyc(0, '0, 1, 0);
        cyc(1, mk(12'h600), 0, 0);
        cyc(0, '0, 0, 0);
        cyc(1, mk(12'hA00), 0, 0);
        check("R4 pixel kept", int'(out_pixel), 12'h600 + 2 * 17);
        idle(6);
        check("R4 overflow set", int'(overflow), 1);
        idle(10);
        // R5: sticky
        check("R5 overflow sticky", int'(overflow), 1);

        // reset clears everything
        rst = 1; cyc(0, '0, 0, 0); rst = 0;
        check("R1 overflow cleared", int'(overflow), 0);
        check("R1 valid cleared", int'(out_valid), 0);

        // short lines, extreme values, frame flag on second frame
        line_len = 16'd4;
        cyc(0, '0, 0, 1); cyc(0, '0, 1, 0);
        beat(12'hFFF);
        cyc(0, '0, 1, 0);
        beat(0);
        cyc(0, '0, 0, 1);
        cyc(1, mk(12'h7F0), 1, 0);
        idle(3);
        idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule